// File: doc/BRIEF.md
# Tiled Depth-Stencil Access Unit

This block turns a pixel coordinate into a byte address in a depth buffer and carries out one depth or stencil access at that location over a 32-bit synchronous memory port. The drawable origin is added to the pixel coordinate first. The resulting position is then mapped in one of two ways. Linear mode gives a plain row-major layout. Tiled mode gives a swizzled micro-tile layout, and its bit arrangement differs between the 16-bit depth format and the packed 24-bit depth / 8-bit stencil format.

In the packed format, a write changes only its own field: depth or stencil. The unit reads the word, merges the new field in, and writes the word back. In the 16-bit format, a write is a single halfword store that uses byte enables. A read returns the field on `rd_data`, qualified by a one-cycle `rd_valid` pulse.

Control is a five-state machine:
- `ST_IDLE` accepts a command.
- `ST_RD_REQ` issues a read and holds it while `mem_wait` is high.
- `ST_RD_WAIT` waits for `mem_rvalid`.
- `ST_WR_REQ` issues a write and holds it while `mem_wait` is high.
- `ST_RESP` pulses `rd_valid`.

The transitions are:
- From `ST_IDLE` on an accepted command:
  - to `ST_RD_REQ` for any packed-format command, and for a 16-bit depth read;
  - to `ST_WR_REQ` for a 16-bit depth write;
  - to `ST_RESP` for a stencil read in 16-bit format;
  - back to `ST_IDLE` for a stencil write in 16-bit format.
- From `ST_RD_REQ` to `ST_RD_WAIT` when `mem_wait` is low.
- From `ST_RD_WAIT`, on `mem_rvalid`, to `ST_WR_REQ` for a write command or to `ST_RESP` for a read command.
- From `ST_WR_REQ` to `ST_IDLE` when `mem_wait` is low.
- From `ST_RESP` to `ST_IDLE`.

Top module: `zs_access_unit`

## Requirements
- R1: The effective position is (cmd_x + org_x, cmd_y + org_y), each sum taken modulo 2^COORD_W, and it is formed before any address mapping.
- R2: With tiled=0, the byte address is B × (X + Y × pitch), where B is 2 when fmt_sel=0 (16-bit depth) and 4 when fmt_sel=1 (packed). mem_addr carries this byte address with bits 1:0 cleared.
- R3: With tiled=1 and fmt_sel=1, let T = (Y/16)×(pitch/16) + X/16. The byte address bits are:
  - [1:0] = 0
  - [4:2] = X[2:0]
  - [6:5] = Y[1:0]
  - [7] = X[4]^Y[2]
  - [9:8] = T[1:0]
  - [10] = Y[3]
  - [11] = X[3]^Y[4]
  - [12 and up] = T >> 2
- R4: With tiled=1 and fmt_sel=0, let T = (Y/16)×(pitch/32) + X/32. The byte address bits are:
  - [0] = 0
  - [3:1] = X[2:0]
  - [6:4] = Y[2:0]
  - [7] = X[3]
  - [9:8] = T[1:0]
  - [10] = Y[3]
  - [11] = X[4]^Y[4]
  - [12 and up] = T >> 2
- R5: In 16-bit format, byte-address bit 1 selects a half of the memory word. 0 selects bits 15:0 with mem_be=4'b0011; 1 selects bits 31:16 with mem_be=4'b1100. A depth write is one write with no preceding read, placing wr_data[15:0] in the selected half.
- R6: In packed format, a depth write reads the word and then writes it back with mem_be=4'b1111. Bits 23:0 become wr_data[23:0] and bits 31:24 are kept.
- R7: In packed format, a stencil write reads the word and then writes it back with mem_be=4'b1111. Bits 31:24 become wr_data[7:0] and bits 23:0 are kept.
- R8: Read results appear on rd_data, zero-extended:
  - packed depth read: word bits 23:0;
  - packed stencil read: word bits 31:24;
  - 16-bit depth read: the selected halfword.
- R9: cmd_op encodes 0 as read depth, 1 as write depth, 2 as read stencil and 3 as write stencil. fmt_sel=0 is 16-bit depth and fmt_sel=1 is packed.
- R10: cmd_ready is low from command acceptance until the last memory request of that command is accepted or its response is given. A request with mem_wait high is repeated unchanged on the next cycle.
- R11: A stencil command in 16-bit format makes no memory access. A stencil read returns rd_data=0 with rd_valid in the cycle after acceptance.
- R12: Every read command yields exactly one single-cycle rd_valid pulse. Write commands yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; command taken when both are high |
| cmd_op | input | 2 | Operation code (R9) |
| cmd_x | input | COORD_W | Pixel x within the drawable |
| cmd_y | input | COORD_W | Pixel y within the drawable |
| org_x | input | COORD_W | Drawable origin x |
| org_y | input | COORD_W | Drawable origin y |
| pitch | input | PITCH_W | Buffer pitch in pixels |
| fmt_sel | input | 1 | 0 = 16-bit depth, 1 = packed depth/stencil |
| tiled | input | 1 | 1 = tiled map, 0 = linear |
| wr_data | input | 24 | Write value (depth or stencil in low bits) |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_wait | input | 1 | Request not accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the unit with COORD_W=10, PITCH_W=10 and ADDR_W=22. The narrow coordinate width lets a directed case push the origin sum past 1023 and observe the modulo wrap of R1. The wider address lets tiled block indices for pitches up to 256 pixels reach the upper address bits without truncation. Random stall and read-latency patterns, including back-to-back merges on one pixel, exercise the hold and ordering rules.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned WVAL_W = 24;

    typedef enum logic [1:0] {
        OP_RD_Z = 2'd0,
        OP_WR_Z = 2'd1,
        OP_RD_S = 2'd2,
        OP_WR_S = 2'd3
    } zs_op_e;

    typedef enum logic {
        FMT_Z16   = 1'b0,
        FMT_Z24S8 = 1'b1
    } zs_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_RESP
    } zs_state_e;

    function automatic logic op_writes(zs_op_e op);
        return op[0];
    endfunction

    function automatic logic op_stencil(zs_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/zs_addr_gen.sv
module zs_addr_gen
    import zs_pkg::*;
#(
    parameter int unsigned COORD_W = 12,
    parameter int unsigned PITCH_W = 12,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] ox,
    input  logic [COORD_W-1:0] oy,
    input  logic [PITCH_W-1:0] pitch,
    input  zs_fmt_e            fmt,
    input  logic               tiled,
    output logic [ADDR_W-2:0]  half_addr
);
    localparam int unsigned HW = ADDR_W - 1;

    logic [COORD_W-1:0] ax, ay;
    logic [HW-1:0]      lin_idx, blk32, blk16;
    logic [HW-1:0]      ha_lin, ha_t32, ha_t16;
    logic [10:0]        low32, low16;

    // origin is folded in before any mapping
    assign ax = px + ox;
    assign ay = py + oy;

    always_comb begin
        lin_idx = HW'(ax) + HW'(ay) * HW'(pitch);
        ha_lin  = (fmt == FMT_Z24S8) ? {lin_idx[HW-2:0], 1'b0} : lin_idx;

        blk32 = HW'(ay[COORD_W-1:4]) * HW'(pitch[PITCH_W-1:4]) + HW'(ax[COORD_W-1:4]);
        blk16 = HW'(ay[COORD_W-1:4]) * HW'(pitch[PITCH_W-1:5]) + HW'(ax[COORD_W-1:5]);

        // halfword-granular fields (byte bit n lands at index n-1)
        low32 = {ax[3] ^ ay[4], ay[3], blk32[1:0], ax[4] ^ ay[2], ay[1:0], ax[2:0], 1'b0};
        low16 = {ax[4] ^ ay[4], ay[3], blk16[1:0], ax[3], ay[2:0], ax[2:0]};

        ha_t32 = ((blk32 >> 2) << 11) | HW'(low32);
        ha_t16 = ((blk16 >> 2) << 11) | HW'(low16);
    end

    always_comb begin
        unique case ({tiled, fmt})
            {1'b0, FMT_Z16},
            {1'b0, FMT_Z24S8}: half_addr = ha_lin;
            {1'b1, FMT_Z24S8}: half_addr = ha_t32;
            default:           half_addr = ha_t16;
        endcase
    end

endmodule

// File: rtl/zs_lane.sv
module zs_lane
    import zs_pkg::*;
(
    input  zs_fmt_e             fmt,
    input  zs_op_e              op,
    input  logic                half_hi,
    input  logic [WORD_W-1:0]   rdata,
    input  logic [WVAL_W-1:0]   wval,
    output logic [WORD_W-1:0]   merged,
    output logic [WORD_W-1:0]   rvalue,
    output logic [3:0]          be
);
    always_comb begin
        unique case (op)
            OP_WR_Z: merged = {rdata[31:24], wval[23:0]};
            OP_WR_S: merged = {wval[7:0], rdata[23:0]};
            default: merged = rdata;
        endcase
    end

    always_comb begin
        if (fmt == FMT_Z16) begin
            rvalue = half_hi ? {16'd0, rdata[31:16]} : {16'd0, rdata[15:0]};
            be     = half_hi ? 4'b1100 : 4'b0011;
        end else begin
            rvalue = op_stencil(op) ? {24'd0, rdata[31:24]} : {8'd0, rdata[23:0]};
            be     = 4'b1111;
        end
    end

endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
    import zs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  zs_op_e  cmd_op,
    input  zs_fmt_e cmd_fmt,
    input  zs_op_e  op_q,
    input  logic    mem_wait,
    input  logic    mem_rvalid,
    output logic    cmd_ready,
    output logic    mem_rd,
    output logic    mem_wr,
    output logic    rd_valid,
    output logic    load_cmd,
    output logic    load_rsp,
    output logic    load_merge
);
    zs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_fmt == FMT_Z16 && op_stencil(cmd_op))
                        state_d = op_writes(cmd_op) ? ST_IDLE : ST_RESP;
                    else if (cmd_fmt == FMT_Z16 && op_writes(cmd_op))
                        state_d = ST_WR_REQ;
                    else
                        state_d = ST_RD_REQ;
                end
            end
            ST_RD_REQ:  if (!mem_wait) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_d = op_writes(op_q) ? ST_WR_REQ : ST_RESP;
            ST_WR_REQ:  if (!mem_wait) state_d = ST_IDLE;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        mem_rd     = (state_q == ST_RD_REQ);
        mem_wr     = (state_q == ST_WR_REQ);
        rd_valid   = (state_q == ST_RESP);
        load_cmd   = (state_q == ST_IDLE) && cmd_valid;
        load_rsp   = (state_q == ST_RD_WAIT) && mem_rvalid && !op_writes(op_q);
        load_merge = (state_q == ST_RD_WAIT) && mem_rvalid && op_writes(op_q);
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_wait) |=> mem_rd);

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !cmd_ready);

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/zs_access_unit.sv
module zs_access_unit
    import zs_pkg::*;
#(
    parameter int unsigned COORD_W = 12,
    parameter int unsigned PITCH_W = 12,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [COORD_W-1:0] cmd_x,
    input  logic [COORD_W-1:0] cmd_y,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               fmt_sel,
    input  logic               tiled,
    input  logic [23:0]        wr_data,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_wait,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata
);
    localparam int unsigned HW = ADDR_W - 1;

    zs_op_e            op_in, op_q;
    zs_fmt_e           fmt_in, fmt_q;
    logic [HW-1:0]     ha_next, ha_q;
    logic [WVAL_W-1:0] wval_q;
    logic [WORD_W-1:0] word_q, rsp_q, merged, rvalue;
    logic              load_cmd, load_rsp, load_merge;

    assign op_in  = zs_op_e'(cmd_op);
    assign fmt_in = zs_fmt_e'(fmt_sel);

    zs_addr_gen #(
        .COORD_W(COORD_W),
        .PITCH_W(PITCH_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .px       (cmd_x),
        .py       (cmd_y),
        .ox       (org_x),
        .oy       (org_y),
        .pitch    (pitch),
        .fmt      (fmt_in),
        .tiled    (tiled),
        .half_addr(ha_next)
    );

    zs_lane u_lane (
        .fmt    (fmt_q),
        .op     (op_q),
        .half_hi(ha_q[0]),
        .rdata  (mem_rdata),
        .wval   (wval_q),
        .merged (merged),
        .rvalue (rvalue),
        .be     (mem_be)
    );

    zs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_in),
        .cmd_fmt   (fmt_in),
        .op_q      (op_q),
        .mem_wait  (mem_wait),
        .mem_rvalid(mem_rvalid),
        .cmd_ready (cmd_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .rd_valid  (rd_valid),
        .load_cmd  (load_cmd),
        .load_rsp  (load_rsp),
        .load_merge(load_merge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_RD_Z;
            fmt_q  <= FMT_Z16;
            ha_q   <= '0;
            wval_q <= '0;
            word_q <= '0;
            rsp_q  <= '0;
        end else begin
            if (load_cmd) begin
                op_q   <= op_in;
                fmt_q  <= fmt_in;
                ha_q   <= ha_next;
                wval_q <= wr_data;
                word_q <= {wr_data[15:0], wr_data[15:0]};
                rsp_q  <= '0;
            end
            if (load_merge) word_q <= merged;
            if (load_rsp)   rsp_q  <= rvalue;
        end
    end

    assign mem_addr  = {ha_q[HW-1:1], 2'b00};
    assign mem_wdata = word_q;
    assign rd_data   = rsp_q;

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_wait) |=> $stable(mem_addr) && $stable(mem_wdata));

    // R11
    no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !(fmt_q == FMT_Z16 && op_stencil(op_q)));

    // R6
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_wr) && fmt_q == FMT_Z24S8) |-> $past(mem_rvalid));

endmodule

// File: tb/test_zs_access_unit.sv
`timescale 1ns/1ps
module test_zs_access_unit;
    localparam int CW = 10;
    localparam int PW = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [CW-1:0] cmd_x = '0, cmd_y = '0, org_x = '0, org_y = '0;
    logic [PW-1:0] pitch = '0;
    logic          fmt_sel = 1'b0, tiled = 1'b0;
    logic [23:0]   wr_data = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic          mem_wait = 1'b0, mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    always #2.5 clk = ~clk;

    zs_access_unit #(.COORD_W(CW), .PITCH_W(PW), .ADDR_W(AW)) i_zs_access_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y), .org_x(org_x), .org_y(org_y),
        .pitch(pitch), .fmt_sel(fmt_sel), .tiled(tiled), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_wait(mem_wait),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int total = 0, fails = 0;
    int nreads = 0, nwrites = 0;
    int unsigned last_rd_addr = 0, last_wr_addr = 0;
    logic [3:0] last_be = '0;
    logic [31:0] bmem [int unsigned];
    bit rd_pend = 0;
    int unsigned rd_addr = 0;
    int rd_delay = 0;

    function automatic logic [31:0] peek(int unsigned wa);
        if (bmem.exists(wa)) return bmem[wa];
        return (wa * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: decides stalls and returns read data at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_wait = 1'b0; mem_rvalid = 1'b0; rd_pend = 0;
        end else begin
            mem_rvalid = 1'b0;
            if (rd_pend) begin
                if (rd_delay == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = peek(rd_addr);
                    rd_pend    = 0;
                end else rd_delay--;
            end
            mem_wait = 1'b0;
            if (mem_rd || mem_wr) begin
                mem_wait = ($urandom % 4) == 0;
                if (!mem_wait) begin
                    if (mem_rd) begin
                        rd_pend = 1; rd_addr = int'(mem_addr); rd_delay = int'($urandom % 3);
                        nreads++; last_rd_addr = int'(mem_addr);
                    end else begin
                        logic [31:0] w;
                        w = peek(int'(mem_addr));
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
                        bmem[int'(mem_addr)] = w;
                        nwrites++; last_wr_addr = int'(mem_addr); last_be = mem_be;
                    end
                end
            end
        end
    end

    function automatic int unsigned exp_addr(int x, int y, int ox, int oy, int p, bit fmt, bit tl);
        int unsigned ax, ay, blk, a;
        ax = (x + ox) & ((1 << CW) - 1);
        ay = (y + oy) & ((1 << CW) - 1);
        if (!tl) a = (fmt ? 4 : 2) * (ax + ay * p);
        else if (fmt) begin
            blk = (ay / 16) * (p / 16) + ax / 16;
            a = ((blk >> 2) << 12) | ((((ax >> 3) ^ (ay >> 4)) & 1) << 11) | (((ay >> 3) & 1) << 10)
              | ((blk & 3) << 8) | ((((ax >> 4) ^ (ay >> 2)) & 1) << 7) | ((ay & 3) << 5) | ((ax & 7) << 2);
        end else begin
            blk = (ay / 16) * (p / 32) + ax / 32;
            a = ((blk >> 2) << 12) | ((((ax >> 4) ^ (ay >> 4)) & 1) << 11) | (((ay >> 3) & 1) << 10)
              | ((blk & 3) << 8) | (((ax >> 3) & 1) << 7) | ((ay & 7) << 4) | ((ax & 7) << 1);
        end
        return a & ((1 << AW) - 1);
    endfunction

    logic [31:0] got_rd;
    int got_nv;

    task automatic issue(int op, int x, int y, int ox, int oy, int p, bit fmt, bit tl, logic [23:0] wv,
                         output bit ready_after);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!cmd_ready && guard < 100) begin @(negedge clk); guard++; end
        cmd_op = op[1:0]; cmd_x = x[CW-1:0]; cmd_y = y[CW-1:0]; org_x = ox[CW-1:0]; org_y = oy[CW-1:0];
        pitch = p[PW-1:0]; fmt_sel = fmt; tiled = tl; wr_data = wv; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        ready_after = cmd_ready;
        got_nv = 0; got_rd = '0; guard = 0;
        while (!cmd_ready && guard < 100) begin
            if (rd_valid) begin got_nv++; got_rd = rd_data; end
            @(negedge clk); guard++;
        end
        if (guard >= 100) chk("R10 hang", 32'd1, 32'd0);
    endtask

    task automatic exec(int op, int x, int y, int ox, int oy, int p, bit fmt, bit tl, logic [23:0] wv);
        int unsigned ea, wa;
        logic [31:0] old, expw;
        int r0, w0;
        bit rdy;
        string atag;
        atag = !tl ? "R2" : (fmt ? "R3" : "R4");
        ea = exp_addr(x, y, ox, oy, p, fmt, tl);
        wa = ea & ~32'd3;
        old = peek(wa);
        r0 = nreads; w0 = nwrites;
        issue(op, x, y, ox, oy, p, fmt, tl, wv, rdy);
        if (!fmt && op >= 2) begin
            chk("R11 access count", nreads - r0 + nwrites - w0, 0);
            if (op == 2) begin
                chk("R11 rd_data", got_rd, 0);
                chk("R12 pulses", got_nv, 1);
            end else chk("R12 pulses", got_nv, 0);
        end else begin
            chk("R10 busy after accept", {31'd0, rdy}, 0);
            if (op == 0 || op == 2) begin
                chk({atag, " read addr"}, last_rd_addr, wa);
                chk("R12 pulses", got_nv, 1);
                chk("R9 read-only", nwrites - w0, 0);
                if (!fmt) chk("R8 halfword", got_rd, ea[1] ? {16'd0, old[31:16]} : {16'd0, old[15:0]});
                else if (op == 0) chk("R8 depth", got_rd, {8'd0, old[23:0]});
                else chk("R8 stencil", got_rd, {24'd0, old[31:24]});
            end else begin
                chk({atag, " write addr"}, last_wr_addr, wa);
                chk("R12 no pulse", got_nv, 0);
                if (!fmt) begin
                    expw = ea[1] ? {wv[15:0], old[15:0]} : {old[31:16], wv[15:0]};
                    chk("R5 no read", nreads - r0, 0);
                    chk("R5 be", {28'd0, last_be}, ea[1] ? 32'hC : 32'h3);
                    chk("R5 word", peek(wa), expw);
                end else if (op == 1) begin
                    chk("R6 rmw counts", (nreads - r0) * 16 + (nwrites - w0), 32'h11);
                    chk("R6 word", peek(wa), {old[31:24], wv[23:0]});
                end else begin
                    chk("R7 rmw counts", (nreads - r0) * 16 + (nwrites - w0), 32'h11);
                    chk("R7 word", peek(wa), {wv[7:0], old[23:0]});
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        bit rdy;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10 reset ready", {31'd0, cmd_ready}, 1);
        chk("R12 reset rd_valid", {31'd0, rd_valid}, 0);
        chk("R10 reset idle port", {30'd0, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        // hand-computed tiled addresses (x=19, y=21, pitch=64)
        issue(0, 19, 21, 0, 0, 64, 1'b1, 1'b1, 24'd0, rdy);
        chk("R3 hand addr", last_rd_addr, 32'h192C);
        issue(0, 19, 21, 0, 0, 64, 1'b0, 1'b1, 24'd0, rdy);
        chk("R4 hand addr", last_rd_addr, 32'h254);
        // linear with origin: (2,1)+(1,1) -> (3,2), 4*(3+2*64) = 0x20C
        issue(2, 2, 1, 1, 1, 64, 1'b1, 1'b0, 24'd0, rdy);
        chk("R1 origin linear", last_rd_addr, 32'h20C);
        // origin wraps modulo 2^CW: 1020+10 -> 6
        issue(0, 1020, 0, 10, 0, 64, 1'b1, 1'b0, 24'd0, rdy);
        chk("R1 wrap", last_rd_addr, 32'd24);

        // packed merge on one pixel, then reads of both fields
        exec(1, 40, 33, 5, 7, 96, 1'b1, 1'b1, 24'hABCDEF);
        exec(3, 40, 33, 5, 7, 96, 1'b1, 1'b1, 24'h00005A);
        exec(0, 40, 33, 5, 7, 96, 1'b1, 1'b1, 24'd0);
        chk("R9 depth kept", got_rd, 32'h00ABCDEF);
        exec(2, 40, 33, 5, 7, 96, 1'b1, 1'b1, 24'd0);
        chk("R9 stencil kept", got_rd, 32'h0000005A);
        // both halves of one 16-bit word
        exec(1, 8, 3, 0, 0, 64, 1'b0, 1'b0, 24'h001234);
        exec(1, 9, 3, 0, 0, 64, 1'b0, 1'b0, 24'h005678);
        exec(0, 8, 3, 0, 0, 64, 1'b0, 1'b0, 24'd0);
        exec(0, 9, 3, 0, 0, 64, 1'b0, 1'b0, 24'd0);
        // stencil commands in 16-bit format
        exec(2, 8, 3, 0, 0, 64, 1'b0, 1'b0, 24'd0);
        exec(3, 8, 3, 0, 0, 64, 1'b0, 1'b1, 24'h0000FF);

        for (int i = 0; i < 400; i++) begin
            exec(int'($urandom % 4), int'($urandom % 256), int'($urandom % 256),
                 int'($urandom % 64), int'($urandom % 64), 32 * (1 + int'($urandom % 8)),
                 1'($urandom % 2), 1'($urandom % 2), 24'($urandom));
        end
        finish_run();
    end

endmodule